// File: doc/BRIEF.md
# Serial Memory Buffer Command Interface

This block is the slave side of a shifted serial command port for a memory device. A 528-byte staging buffer sits behind it. A host selects the device with an active-low chip select, clocks command bits in on SI, and reads results back on SO. SO is only driven while data is being returned. All pins are sampled through synchronizers into the system clock domain, so the serial clock must run several times slower than `clk`.

The command decoder covers several jobs:
- It gathers a 16-bit sector field and a 16-bit byte pointer.
- It runs the pointer across the non-power-of-two buffer.
- It keeps a write-enable latch plus busy and transfer flags.

Loading a sector into the buffer and programming the buffer into the array are both handed to a request/done port. The array side fills the buffer through a separate write port.

Top module: `sfbuf_cmd_if`

## Requirements
- R1: After reset, `so_oe` is low and the status byte reads 0x00.
- R2: Opcode 0x71 or 0x73 is followed by a 16-bit byte address (MSB first) and eight control clocks. SO then returns buffer bytes from that address upward, one byte per eight clocks, each byte MSB first.
- R3: The byte pointer steps from 0x20F to 0x000 for both reads and writes. A start address of 0x210 or above starts at 0x000.
- R4: With `rce`=1, the first data bit is driven at the rising SCK edge of the last control clock, and later bits change on rising edges. With `rce`=0, the first bit appears at the next falling edge, and later bits change on falling edges.
- R5: Opcode 0xF3 is followed by a 16-bit sector field, a 16-bit byte address, data bytes and one trailing zero byte. The data bytes overwrite the buffer from that address. The trailing byte is not stored. When CS rises on a byte boundary, one `arr_req` pulse is issued with `arr_prog`=1 and `arr_sector` equal to sector bits [13:0].
- R6: Opcode 0xF3 takes effect only if `wp`=1, the write-enable latch is set and busy is clear. Otherwise the command changes neither the buffer nor `arr_req`.
- R7: Opcode 0x06 sets the write-enable latch at CS rise. Opcode 0x04 followed by exactly eight clocks clears it at CS rise. Opcode 0x05 returns the status byte with busy in bit 0, the latch in bit 1 and the transfer flag in bit 2.
- R8: Opcode 0x53 is followed by a 16-bit sector field and 32 zero clocks. On the last of these clocks, if busy is clear, the block pulses `arr_req` with `arr_prog`=0 and sets busy and the transfer flag. Bytes written on the fill port land in the buffer.
- R9: Busy and the transfer flag clear on the clock after `arr_done` is seen high.
- R10: If CS rises in the middle of a byte, the command is dropped. No request is issued and the status is unchanged.
- R11: Buffer reads work while busy is set.
- R12: `so_oe` is low whenever the synchronized chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| rce | input | 1 | 1: SO changes on rising SCK, 0: on falling SCK |
| wp | input | 1 | Program permit pin, active high |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | SO output enable (low means high impedance) |
| arr_req | output | 1 | One-cycle array operation request |
| arr_prog | output | 1 | 1: program buffer to sector, 0: load sector into buffer |
| arr_sector | output | SECT_W | Sector number for the request |
| arr_done | input | 1 | Array operation complete |
| fill_we | input | 1 | Array-side buffer write strobe |
| fill_addr | input | AW | Array-side buffer write address |
| fill_data | input | 8 | Array-side buffer write data |

## Verification
The bench builds the block with its defaults: a 528-entry buffer, a 14-bit sector field and two synchronizer stages. With these values the pointer wrap at 0x20F can be reached by a two-byte write that starts at the last valid address. The serial clock runs at one sixteenth of `clk`. The bench samples SO both mid-high and at the end of the low phase, and that separates the two output-edge modes.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  typedef enum logic [3:0] {
    ST_OP, ST_SECT, ST_BADDR, ST_CTRL, ST_RDATA,
    ST_WDATA, ST_ZERO, ST_TAIL, ST_WEN, ST_SKIP
  } sfb_state_t;

  localparam logic [7:0] OPC_RD_A = 8'h71;
  localparam logic [7:0] OPC_RD_B = 8'h73;
  localparam logic [7:0] OPC_XFER = 8'h53;
  localparam logic [7:0] OPC_PROG = 8'hF3;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_RDSR = 8'h05;

  localparam int SB_BUSY = 0;
  localparam int SB_WEL  = 1;
  localparam int SB_TR   = 2;
endpackage

// File: rtl/sfb_pin_sync.sv
module sfb_pin_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sfb_buffer.sv
module sfb_buffer #(
  parameter int DEPTH = 528,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sfb_status.sv
module sfb_status (
  input  logic clk,
  input  logic rst,
  input  logic go_xfer,
  input  logic go_prog,
  input  logic wel_set,
  input  logic wel_clr,
  input  logic done,
  output logic busy,
  output logic wel,
  output logic tr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      tr   <= 1'b0;
      wel  <= 1'b0;
    end else begin
      if (go_xfer || go_prog) begin
        busy <= 1'b1;
        tr   <= go_xfer;
      end else if (done) begin
        busy <= 1'b0;
        tr   <= 1'b0;
      end
      if (wel_set) wel <= 1'b1;
      else if (wel_clr) wel <= 1'b0;
    end
  end
endmodule

// File: rtl/sfbuf_cmd_if.sv
module sfbuf_cmd_if
  import sfb_pkg::*;
#(
  parameter int BUF_BYTES = 528,
  parameter int SECT_W = 14,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              rce,
  input  logic              wp,
  output logic              so,
  output logic              so_oe,
  output logic              arr_req,
  output logic              arr_prog,
  output logic [SECT_W-1:0] arr_sector,
  input  logic              arr_done,
  input  logic              fill_we,
  input  logic [AW-1:0]     fill_addr,
  input  logic [7:0]        fill_data
);
  localparam logic [AW-1:0] LAST = AW'(BUF_BYTES - 1);

  logic cs_s, sck_s, si_s, sck_d, cs_d, rise, fall;
  sfb_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sck, si}), .q({cs_s, sck_s, si_s}));

  sfb_state_t state;
  logic [4:0]  cnt;
  logic [14:0] sh;
  logic [15:0] nxt;
  logic [7:0]  opc;
  logic [AW-1:0] ptr, wr_a;
  logic [7:0]  wr_d, pend_b, rd_q, stat_byte, src_byte;
  logic wr_v, pend_v, prog_ok, src_stat, out_pend;
  logic [2:0] obit;
  logic go_xfer, go_prog, wel_set, wel_clr, busy, wel, tr;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    nxt  = {sh, si_s};
    rise = sck_s & ~sck_d;
    fall = ~sck_s & sck_d;
    stat_byte = '0;
    stat_byte[SB_BUSY] = busy;
    stat_byte[SB_WEL]  = wel;
    stat_byte[SB_TR]   = tr;
    src_byte = src_stat ? stat_byte : rd_q;
  end

  sfb_buffer #(.DEPTH(BUF_BYTES), .DW(8)) u_buf (
    .clk(clk), .we(fill_we | wr_v),
    .waddr(fill_we ? fill_addr : wr_a), .wdata(fill_we ? fill_data : wr_d),
    .raddr(ptr), .rdata(rd_q));

  sfb_status u_stat (
    .clk(clk), .rst(rst), .go_xfer(go_xfer), .go_prog(go_prog),
    .wel_set(wel_set), .wel_clr(wel_clr), .done(arr_done),
    .busy(busy), .wel(wel), .tr(tr));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OP; cnt <= '0; sh <= '0; opc <= '0; ptr <= '0;
      wr_a <= '0; wr_d <= '0; wr_v <= 1'b0; pend_b <= '0; pend_v <= 1'b0;
      prog_ok <= 1'b0; src_stat <= 1'b0; out_pend <= 1'b0; obit <= '0;
      so <= 1'b0; so_oe <= 1'b0; sck_d <= 1'b0; cs_d <= 1'b1;
      arr_req <= 1'b0; arr_prog <= 1'b0; arr_sector <= '0;
      go_xfer <= 1'b0; go_prog <= 1'b0; wel_set <= 1'b0; wel_clr <= 1'b0;
    end else begin
      sck_d <= sck_s; cs_d <= cs_s;
      wr_v <= 1'b0; arr_req <= 1'b0;
      go_xfer <= 1'b0; go_prog <= 1'b0; wel_set <= 1'b0; wel_clr <= 1'b0;
      if (cs_s) begin
        if (!cs_d) begin
          if (state == ST_WDATA && cnt == 5'd0 && pend_v && prog_ok) begin
            arr_req <= 1'b1; arr_prog <= 1'b1; go_prog <= 1'b1;
          end
          if (state == ST_TAIL && cnt == 5'd8) wel_clr <= 1'b1;
          if (state == ST_WEN) wel_set <= 1'b1;
        end
        state <= ST_OP; cnt <= '0; so_oe <= 1'b0; out_pend <= 1'b0; pend_v <= 1'b0;
      end else if (rise) begin
        sh <= nxt[14:0];
        case (state)
          ST_OP: begin
            cnt <= cnt + 1'b1;
            if (cnt == 5'd7) begin
              cnt <= '0;
              opc <= nxt[7:0];
              prog_ok <= wp & wel & ~busy;
              case (nxt[7:0])
                OPC_RD_A, OPC_RD_B: state <= ST_BADDR;
                OPC_XFER, OPC_PROG: state <= ST_SECT;
                OPC_WRDI: state <= ST_TAIL;
                OPC_WREN: state <= ST_WEN;
                OPC_RDSR: begin
                  state <= ST_RDATA; src_stat <= 1'b1;
                  if (rce) begin so <= 1'b0; so_oe <= 1'b1; obit <= 3'd1; end
                  else out_pend <= 1'b1;
                end
                default: state <= ST_SKIP;
              endcase
            end
          end
          ST_SECT: begin
            cnt <= cnt + 1'b1;
            if (cnt == 5'd15) begin
              cnt <= '0;
              arr_sector <= nxt[SECT_W-1:0];
              state <= (opc == OPC_XFER) ? ST_ZERO : ST_BADDR;
            end
          end
          ST_BADDR: begin
            cnt <= cnt + 1'b1;
            if (cnt == 5'd15) begin
              cnt <= '0;
              ptr <= (nxt < 16'(BUF_BYTES)) ? nxt[AW-1:0] : '0;
              state <= (opc == OPC_PROG) ? ST_WDATA : ST_CTRL;
            end
          end
          ST_CTRL: begin
            cnt <= cnt + 1'b1;
            if (cnt == 5'd7) begin
              state <= ST_RDATA; src_stat <= 1'b0;
              if (rce) begin so <= rd_q[7]; so_oe <= 1'b1; obit <= 3'd1; end
              else out_pend <= 1'b1;
            end
          end
          ST_ZERO: begin
            cnt <= cnt + 1'b1;
            if (cnt == 5'd31) begin
              state <= ST_SKIP;
              if (!busy) begin
                arr_req <= 1'b1; arr_prog <= 1'b0; go_xfer <= 1'b1;
              end
            end
          end
          ST_WDATA: begin
            cnt <= cnt + 1'b1;
            if (cnt == 5'd7) begin
              cnt <= '0;
              if (prog_ok && pend_v) begin
                wr_v <= 1'b1; wr_a <= ptr; wr_d <= pend_b; ptr <= step_ptr(ptr);
              end
              pend_b <= nxt[7:0]; pend_v <= 1'b1;
            end
          end
          ST_TAIL: begin
            if (cnt == 5'd8) state <= ST_SKIP;
            else cnt <= cnt + 1'b1;
          end
          ST_WEN: state <= ST_SKIP;
          ST_RDATA: if (rce) begin
            so <= src_byte[~obit]; so_oe <= 1'b1; obit <= obit + 1'b1;
            if (obit == 3'd7 && !src_stat) ptr <= step_ptr(ptr);
          end
          default: ;
        endcase
      end else if (fall && state == ST_RDATA && !rce) begin
        so_oe <= 1'b1; out_pend <= 1'b0;
        if (out_pend) begin
          so <= src_byte[7]; obit <= 3'd1;
        end else begin
          so <= src_byte[~obit]; obit <= obit + 1'b1;
          if (obit == 3'd7 && !src_stat) ptr <= step_ptr(ptr);
        end
      end
    end
  end
endmodule

// File: rtl/sfbuf_cmd_if_chk.sv
module sfbuf_cmd_if_chk #(
  parameter int BUF_BYTES = 528,
  localparam int AW = $clog2(BUF_BYTES)
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_hi,
  input logic          so_oe,
  input logic          arr_req,
  input logic          busy,
  input logic          arr_done,
  input logic [AW-1:0] ptr
);
  // R12
  so_hiz_chk: assert property (@(posedge clk) disable iff (rst) cs_hi |=> !so_oe);
  // R6
  req_idle_chk: assert property (@(posedge clk) disable iff (rst) arr_req |-> !busy);
  // R8
  req_busy_chk: assert property (@(posedge clk) disable iff (rst) arr_req |=> busy);
  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst) arr_req |=> !arr_req);
  // R9
  busy_clear_chk: assert property (@(posedge clk) disable iff (rst) arr_done |=> !busy);
  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst) ptr < AW'(BUF_BYTES));
endmodule

bind sfbuf_cmd_if sfbuf_cmd_if_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst(rst), .cs_hi(cs_s), .so_oe(so_oe), .arr_req(arr_req),
  .busy(busy), .arr_done(arr_done), .ptr(ptr));

// File: tb/sfbuf_cmd_if_bench.sv
`timescale 1ns/1ps
module sfbuf_cmd_if_bench;
  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic rce = 1'b1, wp = 1'b1, arr_done = 1'b0, fill_we = 1'b0;
  logic [9:0] fill_addr = '0;
  logic [7:0] fill_data = '0;
  logic so, so_oe, arr_req, arr_prog;
  logic [13:0] arr_sector;

  always #2.5 clk = ~clk;

  sfbuf_cmd_if u_sfbuf_cmd_if (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .rce(rce), .wp(wp),
    .so(so), .so_oe(so_oe), .arr_req(arr_req), .arr_prog(arr_prog),
    .arr_sector(arr_sector), .arr_done(arr_done), .fill_we(fill_we),
    .fill_addr(fill_addr), .fill_data(fill_data));

  int n_cmp = 0, n_bad = 0, req_cnt = 0;
  logic last_prog = 1'b0;
  logic [13:0] last_sect = '0;
  logic lo_so, lo_oe, hi_oe, finished = 1'b0;

  always @(posedge clk) if (arr_req) begin
    req_cnt <= req_cnt + 1; last_prog <= arr_prog; last_sect <= arr_sector;
  end

  // {rce, start address, first byte, second byte}
  localparam logic [26:0] VEC [6] = '{
    {1'b1, 10'h000, 8'hA5, 8'h3C}, {1'b0, 10'h005, 8'h81, 8'h7E},
    {1'b1, 10'h100, 8'hFF, 8'h00}, {1'b0, 10'h20E, 8'h12, 8'h34},
    {1'b1, 10'h20F, 8'hC3, 8'h5A}, {1'b0, 10'h1FF, 8'h01, 8'h80}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_bit(input logic b);
    si = b;
    wait_clk(7);
    lo_so = so; lo_oe = so_oe;
    wait_clk(1);
    sck = 1'b1;
    wait_clk(6);
    hi_oe = so_oe;
    wait_clk(2);
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sck_bit(b[i]);
  endtask

  task automatic send16(input logic [15:0] w);
    send_byte(w[15:8]); send_byte(w[7:0]);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      sck_bit(1'b0);
      v = {v[6:0], lo_so};
    end
  endtask

  task automatic sel();
    cs_n = 1'b0; wait_clk(8);
  endtask

  task automatic desel();
    wait_clk(4); cs_n = 1'b1; wait_clk(12);
  endtask

  task automatic rd_status(output logic [7:0] v);
    sel(); send_byte(8'h05); recv_byte(v); desel();
  endtask

  task automatic wren();
    sel(); send_byte(8'h06); desel();
  endtask

  task automatic wrdi();
    sel(); send_byte(8'h04); send_byte(8'h00); desel();
  endtask

  task automatic prog2(input logic [15:0] sect, input logic [9:0] a,
                       input logic [7:0] b0, input logic [7:0] b1);
    sel(); send_byte(8'hF3); send16(sect); send16({6'd0, a});
    send_byte(b0); send_byte(b1); send_byte(8'h00); desel();
  endtask

  task automatic rd2(input logic [9:0] a, output logic [7:0] b0,
                     output logic [7:0] b1, output logic oe_ctrl);
    sel(); send_byte(8'h71); send16({6'd0, a}); send_byte(8'h00);
    oe_ctrl = hi_oe;
    recv_byte(b0); recv_byte(b1); desel();
  endtask

  task automatic pulse_done();
    wait_clk(3); arr_done = 1'b1; wait_clk(1); arr_done = 1'b0; wait_clk(3);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1; n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [7:0] st, b0, b1;
    logic oe_c;
    int rc;
    wait_clk(6); rst = 1'b0; wait_clk(4);
    chk("R1 so_oe after reset", so_oe, 0);
    rd_status(st);
    chk("R1 status after reset", st, 8'h00);
    chk("R12 so_oe with CS high", so_oe, 0);
    wren(); rd_status(st);
    chk("R7 status after write enable", st, 8'h02);

    for (int i = 0; i < 6; i++) begin
      rce = VEC[i][26];
      wren();
      rc = req_cnt;
      prog2(16'(i + 1), VEC[i][25:16], VEC[i][15:8], VEC[i][7:0]);
      chk("R5 program request count", req_cnt, rc + 1);
      chk("R5 program request kind", last_prog, 1);
      chk("R5 program sector", last_sect, 14'(i + 1));
      pulse_done();
      rd2(VEC[i][25:16], b0, b1, oe_c);
      chk("R4 SO enabled mid-high of last control clock", oe_c, VEC[i][26]);
      chk("R2 R3 first byte read back", b0, VEC[i][15:8]);
      chk("R2 R3 second byte read back", b1, VEC[i][7:0]);
    end
    rce = 1'b1;

    wrdi(); rd_status(st);
    chk("R7 status after write disable", st, 8'h00);
    rc = req_cnt;
    prog2(16'h0009, 10'h005, 8'hEE, 8'hEE);
    chk("R6 no request with latch clear", req_cnt, rc);
    rd2(10'h005, b0, b1, oe_c);
    chk("R6 buffer untouched with latch clear", b0, 8'h81);

    wren(); wp = 1'b0;
    prog2(16'h0009, 10'h005, 8'h22, 8'h22);
    chk("R6 no request with wp low", req_cnt, rc);
    rd2(10'h005, b0, b1, oe_c);
    chk("R6 buffer untouched with wp low", b0, 8'h81);
    wp = 1'b1;

    sel(); send_byte(8'hF3); send16(16'h0003); send16(16'h0005);
    send_byte(8'h55); sck_bit(1'b1); sck_bit(1'b0); sck_bit(1'b1); desel();
    chk("R10 no request after mid-byte abort", req_cnt, rc);
    rd_status(st);
    chk("R10 status unchanged after abort", st, 8'h02);
    rd2(10'h005, b0, b1, oe_c);
    chk("R10 buffer unchanged after abort", b0, 8'h81);

    sel(); send_byte(8'h53); send16(16'h1234); send16(16'h0000);
    wait_clk(1);
    chk("R8 request before zero field ends", req_cnt, rc);
    send16(16'h0000);
    chk("R8 transfer request issued", req_cnt, rc + 1);
    desel();
    chk("R8 transfer request kind", last_prog, 0);
    chk("R8 transfer sector", last_sect, 14'h1234);
    rd_status(st);
    chk("R8 busy and transfer flag set", st, 8'h07);
    rd2(10'h000, b0, b1, oe_c);
    chk("R11 read while busy", b0, 8'h5A);
    wait_clk(1);
    fill_we = 1'b1; fill_addr = 10'h000; fill_data = 8'h9C; wait_clk(1);
    fill_addr = 10'h001; fill_data = 8'h6D; wait_clk(1);
    fill_we = 1'b0;
    prog2(16'h0004, 10'h001, 8'h11, 8'h11);
    chk("R6 no request while busy", req_cnt, rc + 1);
    pulse_done();
    rd_status(st);
    chk("R9 flags clear after done", st, 8'h02);
    rd2(10'h000, b0, b1, oe_c);
    chk("R8 filled byte 0", b0, 8'h9C);
    chk("R8 filled byte 1", b1, 8'h6D);
    chk("R12 so_oe after deselect", so_oe, 0);

    rce = 1'b0;
    rd2(10'h20F, b0, b1, oe_c);
    chk("R4 SO stays off mid-high with rce low", oe_c, 0);
    chk("R3 wrap read 0x20F", b0, 8'hC3);
    chk("R3 wrap read 0x000", b1, 8'h9C);

    if (!finished) begin
      finished = 1'b1;
      summary();
    end
  end
endmodule